// File: doc/BRIEF.md
# Word-Addressed Data Memory with Range Error

This block is the data store of a small processor. It holds a parameterised number of 32-bit words behind one address port, with a write-data bus, a read-data bus, and separate read and write enables. A read is combinational: while a legal read is requested, the read-data bus follows the addressed word with no clock involved. A write is committed only at the rising clock edge, so the written value is visible from the following cycle.

Each cycle carries at most one operation. The error output is combinational and flags any request that cannot be served: an address at or beyond the implemented depth, or read and write requested together. A flagged request touches no stored word and drives zero on the read-data bus. A synchronous active-high reset clears every word to zero.

Top module: `dmem_unit`

## Requirements
- R1: With wr_en=1, rd_en=0 and addr < DEPTH, the word at addr takes wr_data at the rising clock edge and reads back as that value from the next cycle on.
- R2: With rd_en=1, wr_en=0 and addr < DEPTH, rd_data equals the stored word at addr in the same cycle, and err is 0.
- R3: When rd_en or wr_en is 1 and addr >= DEPTH (default DEPTH 48, so 48 to 255 are illegal), err is 1 in the same cycle.
- R4: A write to an address >= DEPTH leaves every stored word unchanged, including the word whose index equals the low address bits.
- R5: A read from an address >= DEPTH drives rd_data to 0.
- R6: rd_en=1 together with wr_en=1 is illegal at any address: err is 1, rd_data is 0 and no word is written.
- R7: With rd_en=0 and wr_en=0, err is 0 and rd_data is 0 for every address value.
- R8: A synchronous reset (rst=1 at a rising edge) sets every stored word to 0.
- R9: A legal write keeps err at 0 and rd_data at 0 during its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all words |
| addr | input | ADDR_W (8) | Word address for the current request |
| wr_data | input | 32 | Value to store on a legal write |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| rd_data | output | 32 | Addressed word on a legal read, else 0 |
| err | output | 1 | Illegal request flag, combinational |

## Verification
The error flag and the read data are combinational, so both are due in the cycle the request is presented; the bench drives each request at the falling edge and samples one nanosecond later, before the next rising edge. A write lands at the rising edge that ends its cycle, so its effect is checked by a read in the following cycle against an associative-array model that is updated only for legal writes. Out-of-range writes whose low bits alias a legal index are followed by reads of that index to show nothing moved.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int DATA_W = 32;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        REQ_IDLE  = 2'd0,
        REQ_READ  = 2'd1,
        REQ_WRITE = 2'd2,
        REQ_BOTH  = 2'd3
    } req_e;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
        logic err;
    } acc_t;

    function automatic req_e classify(input logic rd, input logic wr);
        case ({wr, rd})
            2'b01:   return REQ_READ;
            2'b10:   return REQ_WRITE;
            2'b11:   return REQ_BOTH;
            default: return REQ_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
    import dmem_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 48,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output acc_t              ctl,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    req_e kind;
    logic in_range;

    always_comb begin
        kind     = classify(rd_en, wr_en);
        in_range = ({1'b0, addr} < LIMIT);
        idx      = addr[IDX_W-1:0];
        ctl      = '0;
        unique case (kind)
            REQ_READ: begin
                ctl.rd_ok = in_range;
                ctl.err   = !in_range;
            end
            REQ_WRITE: begin
                ctl.wr_ok = in_range;
                ctl.err   = !in_range;
            end
            REQ_BOTH:  ctl.err = 1'b1;
            default:   ctl = '0;
        endcase
    end

endmodule

// File: rtl/dmem_array.sv
module dmem_array
    import dmem_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  word_t            wdata,
    output word_t            rword
);

    word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    always_comb rword = mem_q[idx];

    // R1: a committed write is found at its index one edge later
    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> mem_q[$past(idx)] == $past(wdata));

    // R8: reset leaves the first and last words cleared
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (mem_q[0] == '0) && (mem_q[DEPTH-1] == '0));

endmodule

// File: rtl/dmem_unit.sv
module dmem_unit
    import dmem_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 48
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [dmem_pkg::DATA_W-1:0] wr_data,
    input  logic                      rd_en,
    input  logic                      wr_en,
    output logic [dmem_pkg::DATA_W-1:0] rd_data,
    output logic                      err
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    acc_t             ctl;
    logic [IDX_W-1:0] idx;
    word_t            rword;

    dmem_decode #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W)
    ) u_decode (
        .addr  (addr),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .ctl   (ctl),
        .idx   (idx)
    );

    dmem_array #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl.wr_ok),
        .idx   (idx),
        .wdata (wr_data),
        .rword (rword)
    );

    always_comb begin
        rd_data = ctl.rd_ok ? rword : '0;
        err     = ctl.err;
    end

    // R3: out-of-range request is flagged
    a_r3_range_flag: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && (int'(addr) >= DEPTH)) |-> err);

    // R4: a flagged request never reaches the store
    a_r4_no_store_on_error: assert property (@(posedge clk) disable iff (rst)
        err |-> !ctl.wr_ok);

    // R5: read data is zero on any flagged request
    a_r5_zero_on_error: assert property (@(posedge clk) disable iff (rst)
        err |-> (rd_data == '0));

    // R6: both enables together is illegal
    a_r6_dual_request: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en) |-> (err && !ctl.wr_ok));

    // R7: idle cycle is quiet
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en) |-> (!err && rd_data == '0));

endmodule

// File: tb/dmem_unit_test.sv
`timescale 1ns/1ps
module dmem_unit_test;

    localparam int ADDR_W = 8;
    localparam int DEPTH  = 48;
    localparam int NVEC   = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] rd_data;
    logic        err;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [int];

    // vector: {rd, wr, addr, data}
    localparam logic [41:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 8'd0,   32'h1111_0000},
        {1'b0, 1'b1, 8'd3,   32'hDEAD_0003},
        {1'b0, 1'b1, 8'd47,  32'hCAFE_002F},
        {1'b1, 1'b0, 8'd0,   32'h0},
        {1'b1, 1'b0, 8'd3,   32'h0},
        {1'b1, 1'b0, 8'd47,  32'h0},
        {1'b1, 1'b0, 8'd48,  32'h0},
        {1'b0, 1'b1, 8'd48,  32'hBAD0_0030},
        {1'b0, 1'b1, 8'd67,  32'hBAD0_0043},
        {1'b1, 1'b0, 8'd3,   32'h0},
        {1'b1, 1'b1, 8'd5,   32'h5555_5555},
        {1'b1, 1'b0, 8'd5,   32'h0},
        {1'b0, 1'b0, 8'd200, 32'h0},
        {1'b1, 1'b0, 8'd255, 32'h0},
        {1'b0, 1'b1, 8'd3,   32'h0000_0033},
        {1'b1, 1'b0, 8'd3,   32'h0}
    };

    dmem_unit #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uut (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .rd_data (rd_data),
        .err     (err)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] stored(input int a);
        return model.exists(a) ? model[a] : 32'h0;
    endfunction

    // drive at the falling edge, sample 1 ns later (combinational results)
    task automatic do_op(input logic rd, input logic wr, input logic [7:0] a,
                         input logic [31:0] d, input string req);
        logic exp_err;
        logic [31:0] exp_data;
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; wr_data = d;
        #1;
        exp_err  = (rd || wr) && ((rd && wr) || (int'(a) >= DEPTH));
        exp_data = (rd && !wr && int'(a) < DEPTH) ? stored(int'(a)) : 32'h0;
        chk({req, " err"}, {31'b0, err}, {31'b0, exp_err});
        chk({req, " rd_data"}, rd_data, exp_data);
        if (wr && !rd && int'(a) < DEPTH) model[int'(a)] = d;
    endtask

    task automatic reset_pulse();
        @(negedge clk);
        rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model.delete();
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        reset_pulse();
        // R8: reset state reads zero everywhere sampled
        do_op(1'b1, 1'b0, 8'd0,  32'h0, "R8 reset word0");
        do_op(1'b1, 1'b0, 8'd47, 32'h0, "R8 reset word47");
        do_op(1'b0, 1'b0, 8'd0,  32'h0, "R7 idle after reset");

        // table walk: R1 R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NVEC; i++) begin
            do_op(VEC[i][41], VEC[i][40], VEC[i][39:32], VEC[i][31:0], "R1/R2/R3/R4/R5/R6/R7/R9 vector");
        end

        // R4: aliasing out-of-range writes (low bits hit words 0 and 3)
        do_op(1'b0, 1'b1, 8'd64,  32'hFFFF_0040, "R4 alias write 64");
        do_op(1'b0, 1'b1, 8'd131, 32'hFFFF_0083, "R4 alias write 131");
        do_op(1'b1, 1'b0, 8'd0,   32'h0, "R4 word0 unchanged");
        do_op(1'b1, 1'b0, 8'd3,   32'h0, "R4 word3 unchanged");
        for (int a = 0; a < DEPTH; a++) do_op(1'b1, 1'b0, 8'(a), 32'h0, "R4 sweep");

        // R6: dual request at a written address does not overwrite it
        do_op(1'b1, 1'b1, 8'd47, 32'h0BAD_BEEF, "R6 dual");
        do_op(1'b1, 1'b0, 8'd47, 32'h0, "R6 word47 kept");

        // R1 R9: back-to-back writes to neighbouring boundary word
        do_op(1'b0, 1'b1, 8'd46, 32'h1234_5678, "R9 write 46");
        do_op(1'b0, 1'b1, 8'd46, 32'h8765_4321, "R9 rewrite 46");
        do_op(1'b1, 1'b0, 8'd46, 32'h0, "R1 readback 46");

        // R7: idle with illegal address
        do_op(1'b0, 1'b0, 8'd255, 32'hFFFF_FFFF, "R7 idle high addr");

        // R8: reset after writes clears them
        reset_pulse();
        do_op(1'b1, 1'b0, 8'd3,  32'h0, "R8 word3 cleared");
        do_op(1'b1, 1'b0, 8'd46, 32'h0, "R8 word46 cleared");

        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule